// File: doc/BRIEF.md
# Three-Wire Serial Control Word Receiver

This block takes 32-bit control words from a host microcontroller over three slow lines: a serial clock, a data line and a latch line. It samples all three lines in a faster system clock, shifts one data bit in on every rising edge of the serial clock, and on the rising edge of the latch line commits the word to one of three register banks. Two slot bits carried at the end of the word pick the bank.

One bank holds general controls, such as the record-output enables and the balance/loudness mode. The other two each hold four 7-bit attenuation codes, and the first of them also holds an all-channel mute bit and a loudness enable. The decoded fields leave the block as parallel buses that analog switch control logic reads directly. A one-cycle pulse tagged with the slot code marks each accepted word. A second one-cycle pulse flags a latch that arrives after the wrong number of bits.

Top module: `serial_ctl_rx`

## Requirements
- R1: On each rising edge of `ser_clk` the block captures one bit of `ser_dat`. The first bit after a latch is D0, and it lands in word bit 0.
- R2: A latch rising edge after exactly 32 bits with slot code 00 loads `gen_ctrl` with D0..D29. `rec_en[k]` then reads D(22+k), `loud_mode` reads D26, and the volume banks keep their values.
- R3: A 32-bit frame with slot code 01 loads `vol_a`, `mute_all` from D28 and `loud_en` from D29. Field k of `vol_a` (bits 7k+6..7k) takes D(7k) as its MSB down to D(7k+6) as its LSB. Codes 0..92, 95 and 120 (mute) pass through unchanged.
- R4: A 32-bit frame with slot code 10 loads `vol_b`, with the same field layout and bit order as R3. Nothing else changes.
- R5: The slot code is formed with D30 as its MSB and D31 as its LSB. Code 11 is reserved: such a frame changes no register and raises neither `commit` nor `frame_err`.
- R6: Each accepted frame raises `commit` for exactly one system clock. `commit_slot` carries the frame's slot code.
- R7: A latch after any bit count other than 32, including zero or more than 32, raises `frame_err` for one cycle. It changes no register and does not raise `commit`.
- R8: While `rst_n` is low, every output is zero.
- R9: Every latch edge restarts the bit count, so the frame after a dropped frame is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial bit clock from the host |
| ser_dat | input | 1 | Serial data, D0 first |
| ser_lat | input | 1 | Latch line; its rising edge commits the frame |
| gen_ctrl | output | 30 | General control bank, D0..D29 |
| rec_en | output | 4 | Record output enables |
| loud_mode | output | 1 | 0 = balance output, 1 = loudness |
| vol_a | output | 28 | First volume bank, four 7-bit codes |
| vol_b | output | 28 | Second volume bank, four 7-bit codes |
| mute_all | output | 1 | All-channel output mute |
| loud_en | output | 1 | Loudness enable |
| commit | output | 1 | One-cycle pulse per accepted frame |
| commit_slot | output | 2 | Slot code of the accepted frame |
| frame_err | output | 1 | One-cycle pulse on a bad bit count |

## Verification
The bench builds the block with its default parameters: a 32-bit frame, a two-stage synchronizer and four 7-bit fields per volume bank. Each serial line phase is held for six system clocks, which keeps both synchronized edges and the setup of data before the serial clock within reach. With these values the reversed field bit order, the slot decoding of D30/D31, the reserved slot and the short, long and empty frames can all be driven at the ports and observed there.

// File: rtl/serial_ctl_rx.sv
module serial_ctl_rx #(
  parameter int FRAME_BITS  = 32,
  parameter int SYNC_STAGES = 2,
  parameter int VOL_W       = 7,
  parameter int VOL_FIELDS  = 4,
  parameter int REC_N       = 4,
  parameter int REC_LSB     = 22,
  parameter int MODE_BIT    = 26
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ser_clk,
  input  logic                        ser_dat,
  input  logic                        ser_lat,
  output logic [FRAME_BITS-3:0]       gen_ctrl,
  output logic [REC_N-1:0]            rec_en,
  output logic                        loud_mode,
  output logic [VOL_W*VOL_FIELDS-1:0] vol_a,
  output logic [VOL_W*VOL_FIELDS-1:0] vol_b,
  output logic                        mute_all,
  output logic                        loud_en,
  output logic                        commit,
  output logic [1:0]                  commit_slot,
  output logic                        frame_err
);
  localparam int PAY_W    = FRAME_BITS - 2;
  localparam int VOLS_W   = VOL_W * VOL_FIELDS;
  localparam int MUTE_BIT = VOLS_W;
  localparam int LOUD_BIT = VOLS_W + 1;
  localparam int CNT_W    = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);

  logic [SYNC_STAGES:0]   clk_sr, lat_sr;
  logic [SYNC_STAGES-1:0] dat_sr;
  logic [FRAME_BITS-1:0]  shreg;
  logic [CNT_W-1:0]       cnt;
  logic [VOLS_W-1:0]      vol_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_sr <= '0;
      lat_sr <= '0;
      dat_sr <= '0;
    end else begin
      clk_sr <= {clk_sr[SYNC_STAGES-1:0], ser_clk};
      lat_sr <= {lat_sr[SYNC_STAGES-1:0], ser_lat};
      dat_sr <= {dat_sr[SYNC_STAGES-2:0], ser_dat};
    end
  end

  wire       clk_rise = clk_sr[SYNC_STAGES-1] & ~clk_sr[SYNC_STAGES];
  wire       lat_rise = lat_sr[SYNC_STAGES-1] & ~lat_sr[SYNC_STAGES];
  wire       dat_bit  = dat_sr[SYNC_STAGES-1];
  wire [1:0] slot     = {shreg[FRAME_BITS-2], shreg[FRAME_BITS-1]};
  wire       full     = (cnt == CNT_FULL);

  for (genvar k = 0; k < VOL_FIELDS; k++) begin : g_field
    for (genvar j = 0; j < VOL_W; j++) begin : g_bit
      assign vol_in[k*VOL_W + VOL_W-1-j] = shreg[k*VOL_W + j];
    end
  end

  assign rec_en    = gen_ctrl[REC_LSB +: REC_N];
  assign loud_mode = gen_ctrl[MODE_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg       <= '0;
      cnt         <= '0;
      gen_ctrl    <= '0;
      vol_a       <= '0;
      vol_b       <= '0;
      mute_all    <= 1'b0;
      loud_en     <= 1'b0;
      commit      <= 1'b0;
      commit_slot <= 2'b00;
      frame_err   <= 1'b0;
    end else begin
      commit    <= 1'b0;
      frame_err <= 1'b0;
      if (lat_rise) begin
        cnt <= '0;
        if (!full) begin
          frame_err <= 1'b1;
        end else begin
          case (slot)
            2'b00: gen_ctrl <= shreg[PAY_W-1:0];
            2'b01: begin
              vol_a    <= vol_in;
              mute_all <= shreg[MUTE_BIT];
              loud_en  <= shreg[LOUD_BIT];
            end
            2'b10: vol_b <= vol_in;
            default: ;
          endcase
          if (slot != 2'b11) begin
            commit      <= 1'b1;
            commit_slot <= slot;
          end
        end
      end else if (clk_rise) begin
        shreg <= {dat_bit, shreg[FRAME_BITS-1:1]};
        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
      end
    end
  end

  a_r2_gen_only_slot0: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gen_ctrl) |-> (commit && commit_slot == 2'b00));
  a_r3_vola_only_slot1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(vol_a) || !$stable(mute_all) || !$stable(loud_en)) |-> (commit && commit_slot == 2'b01));
  a_r4_volb_only_slot2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vol_b) |-> (commit && commit_slot == 2'b10));
  a_r5_no_reserved_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> commit_slot != 2'b11);
  a_r6_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
  a_r7_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);
  a_r7_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !commit);
endmodule

// File: tb/serial_ctl_rx_test.sv
`timescale 1ns/1ps
module serial_ctl_rx_test;
  logic clk = 0, rst_n = 0, ser_clk = 0, ser_dat = 0, ser_lat = 0;
  logic [29:0] gen_ctrl;
  logic [3:0]  rec_en;
  logic        loud_mode, mute_all, loud_en, commit, frame_err;
  logic [27:0] vol_a, vol_b;
  logic [1:0]  commit_slot;

  serial_ctl_rx uut (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_lat(ser_lat), .gen_ctrl(gen_ctrl), .rec_en(rec_en), .loud_mode(loud_mode),
    .vol_a(vol_a), .vol_b(vol_b), .mute_all(mute_all), .loud_en(loud_en),
    .commit(commit), .commit_slot(commit_slot), .frame_err(frame_err));

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0, n_commit = 0, n_err = 0;
  logic [1:0] last_slot = 2'b00;
  bit done = 0;

  always @(negedge clk) begin
    if (commit) begin n_commit++; last_slot = commit_slot; end
    if (frame_err) n_err++;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] w, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      ser_dat = (i < 32) ? w[i] : 1'b0;
      tick(6); ser_clk = 1; tick(6); ser_clk = 0;
    end
    tick(6); ser_lat = 1; tick(6); ser_lat = 0; tick(8);
  endtask

  // row: slot, c0, c1, c2, c3, D28, D29
  localparam logic [31:0] VT [5] = '{
    {2'b01, 7'd0,   7'd1,  7'd92, 7'd95, 1'b0, 1'b1},
    {2'b10, 7'd120, 7'd64, 7'd33, 7'd7,  1'b0, 1'b0},
    {2'b01, 7'd120, 7'd120,7'd120,7'd120,1'b1, 1'b0},
    {2'b10, 7'd0,   7'd0,  7'd0,  7'd0,  1'b0, 1'b0},
    {2'b01, 7'd85,  7'd42, 7'd17, 7'd3,  1'b1, 1'b1}
  };

  function automatic logic [31:0] build(input logic [1:0] s, input logic [27:0] codes,
                                        input logic x28, input logic x29);
    logic [31:0] w = '0;
    for (int k = 0; k < 4; k++)
      for (int j = 0; j < 7; j++)
        w[7*k + j] = codes[7*k + 6 - j];
    w[28] = x28; w[29] = x29; w[30] = s[1]; w[31] = s[0];
    return w;
  endfunction

  initial begin
    tick(50000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [27:0] exp_a = '0, exp_b = '0, codes;
    logic [29:0] gpat;
    int pc, pe;
    tick(5);
    check("R8 reset gen", gen_ctrl, 0);
    check("R8 reset vols", {vol_a, vol_b}, 0);
    check("R8 reset flags", {mute_all, loud_en, commit, frame_err, commit_slot}, 0);
    rst_n = 1; tick(3);

    for (int r = 0; r < 5; r++) begin
      logic [1:0] s = VT[r][31:30];
      codes = {VT[r][8:2], VT[r][15:9], VT[r][22:16], VT[r][29:23]};
      pc = n_commit;
      send(build(s, codes, VT[r][1], VT[r][0]), 32);
      if (s == 2'b01) exp_a = codes; else exp_b = codes;
      check("R1 R3 vol_a", vol_a, exp_a);
      check("R4 vol_b", vol_b, exp_b);
      if (s == 2'b01) check("R3 mute/loud", {mute_all, loud_en}, {VT[r][1], VT[r][0]});
      check("R6 one pulse", n_commit - pc, 1);
      check("R6 slot tag", last_slot, s);
    end

    gpat = 30'h2A5C_3E19;
    pc = n_commit;
    send({2'b00, gpat}, 32);
    check("R2 gen_ctrl", gen_ctrl, gpat);
    check("R2 rec_en", rec_en, gpat[25:22]);
    check("R2 loud_mode", loud_mode, gpat[26]);
    check("R2 vols kept", {vol_a, vol_b}, {exp_a, exp_b});
    check("R6 slot 00", {n_commit - pc, last_slot}, {32'd1, 2'b00});

    pc = n_commit; pe = n_err;
    send({2'b11, 30'h1555_5555}, 32);
    check("R5 reserved regs", {gen_ctrl, vol_a, vol_b}, {gpat, exp_a, exp_b});
    check("R5 no pulses", {n_commit - pc, n_err - pe}, 0);

    pc = n_commit; pe = n_err;
    send(build(2'b01, 28'h0, 1'b0, 1'b0), 31);
    check("R7 short err", n_err - pe, 1);
    check("R7 short regs", {vol_a, vol_b, commit, frame_err}, {exp_a, exp_b, 2'b00});
    send(build(2'b10, 28'h0, 1'b0, 1'b0), 33);
    check("R7 long err", n_err - pe, 2);
    send(32'h0, 0);
    check("R7 empty err", n_err - pe, 3);
    check("R7 no commit", n_commit - pc, 0);
    check("R7 regs kept", {gen_ctrl, vol_a, vol_b}, {gpat, exp_a, exp_b});

    codes = {7'd5, 7'd6, 7'd91, 7'd2};
    send(build(2'b10, codes, 1'b0, 1'b0), 32);
    check("R9 realign vol_b", vol_b, codes);
    check("R9 pulse", n_commit - pc, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule